// File: doc/BRIEF.md
# Dual-Half Registered Bus Transceiver

This block passes data in both directions between an A side and a B side. It is split into halves that are fully independent of each other. Each half has its own controls for A-to-B and B-to-A, so several halves can also be driven with identical controls and used as one wide path. In each direction a storage cell sits between the source side and the destination side. The cell has three behaviours, chosen by a level control (latch enable) and a strobe input (the local clock):

- Latch enable high: the cell is transparent.
- Latch enable low and strobe steady: the cell holds its value.
- Latch enable low and strobe rising: the cell captures the source.

Each direction has its own output enable, and the two enables have opposite polarity. A-to-B is enabled high. B-to-A is enabled low.

The pads are modelled as split vectors. Each side has an input, a per-bit "driven" qualifier, an output and an output-enable. An output that is not enabled reads as zero. Every source input goes through a bus-hold keeper. The keeper remembers the last value that was externally driven and supplies it when the driver lets go. A per-half flag rises when both directions of that half are enabled at once.

The strobe and latch-enable are sampled on the system clock `clk`. A strobe edge is a strobe that is high at one `clk` edge and was low at the previous one. A synchronous, active-high `rst` clears every storage cell and keeper. It also makes the strobe history read as high, so a strobe held high across reset does not count as an edge.

Top module: `utx_transceiver`

## Requirements
- R1: When a direction's latch enable is high and its output is enabled, the destination output equals the effective source data in the same cycle, with no clock edge needed.
- R2: While latch enable stays low and the strobe shows no rising edge, the destination output keeps its stored value, and changes on the source data and falling strobe levels have no effect.
- R3: With latch enable low, a strobe sampled high at a `clk` edge after being sampled low at the previous edge captures the source data at that edge. The captured value appears on the destination output from then on.
- R4: If latch enable falls while the strobe is high, the held value is the source data present in the last cycle that latch enable was high. The still-high strobe captures nothing afterwards.
- R5: The A-to-B enable is active high. When it is low, every B output bit of that half and its B output-enable bit read 0, whatever the latch enable, strobe and data do. When it is high, all B output-enable bits of that half read 1.
- R6: The B-to-A enable is active low. When it is high, every A output bit and A output-enable bit of that half read 0. When it is low, all A output-enable bits of that half read 1.
- R7: Half h owns data bits [h*HALF_W +: HALF_W] and is steered only by control bit h. The controls of one half never change the outputs of another.
- R8: A source bit whose "driven" qualifier is low takes the value that bit last had at a `clk` edge where it was driven. This is decided bit by bit.
- R9: Flag `fight[h]` is 1 exactly when half h has its A-to-B enable high and its B-to-A enable low at the same time.
- R10: A `clk` edge with `rst` high clears all storage cells and keepers to zero. A strobe already high when reset is released captures nothing until it has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobes, latch enables and keepers |
| rst | input | 1 | Synchronous active-high clear |
| a_in | input | HALF_W*HALVES | Data arriving on the A side |
| a_drv | input | HALF_W*HALVES | Per-bit qualifier: A bit is externally driven |
| b_in | input | HALF_W*HALVES | Data arriving on the B side |
| b_drv | input | HALF_W*HALVES | Per-bit qualifier: B bit is externally driven |
| ab_en | input | HALVES | A-to-B output enable per half, active high |
| ab_le | input | HALVES | A-to-B latch enable per half |
| ab_stb | input | HALVES | A-to-B capture strobe per half |
| ba_en_n | input | HALVES | B-to-A output enable per half, active low |
| ba_le | input | HALVES | B-to-A latch enable per half |
| ba_stb | input | HALVES | B-to-A capture strobe per half |
| b_out | output | HALF_W*HALVES | Data driven toward the B side (0 when released) |
| b_oe | output | HALF_W*HALVES | Per-bit B drive enable |
| a_out | output | HALF_W*HALVES | Data driven toward the A side (0 when released) |
| a_oe | output | HALF_W*HALVES | Per-bit A drive enable |
| fight | output | HALVES | Both directions of a half enabled together |

## Verification
The bench aims first at the moment latch enable drops while the strobe is high. A cell that treats that level as an edge would load the newer data, and the bench catches this. It then confirms that a falling strobe and a held-high strobe leave the stored value alone. A design that captured on levels or on either edge would show the later source pattern instead. Only one half is strobed in one phase, which exposes control bits crossed between halves. The keeper is checked by releasing all bits and then re-driving only the low half, so a keeper that fell to zero or tracked the floating input would read wrong. A reset applied with the strobe held high shows whether the edge history wrongly restarts from low.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
package utx_pkg;

    // control pair steering one direction's storage cell
    typedef struct packed {
        logic le;   // transparent while high
        logic stb;  // capture strobe, rising edge active
    } ctl_t;

    // storage cell behaviour selected by the control pair
    typedef enum logic [1:0] {
        CELL_HOLD    = 2'd0,
        CELL_FOLLOW  = 2'd1,
        CELL_CAPTURE = 2'd2
    } cell_mode_t;

    function automatic cell_mode_t cell_mode(ctl_t c, logic stb_prev);
        if (c.le)
            return CELL_FOLLOW;
        else if (c.stb && !stb_prev)
            return CELL_CAPTURE;
        else
            return CELL_HOLD;
    endfunction

endpackage

// File: rtl/utx_keeper.sv
`timescale 1ns/1ps
module utx_keeper #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] pin_drv,
    output logic [W-1:0] eff
);
    logic [W-1:0] held;

    // a driven bit passes straight through, a released bit shows its last driven level
    assign eff = (pin_drv & pin_in) | (~pin_drv & held);

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else
            held <= eff;
    end
endmodule

// File: rtl/utx_cell.sv
`timescale 1ns/1ps
module utx_cell
    import utx_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_out
);
    logic [W-1:0] q;
    logic         stb_prev;
    cell_mode_t   mode;

    assign mode  = cell_mode(ctl, stb_prev);
    assign q_out = (mode == CELL_FOLLOW) ? d : q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            stb_prev <= 1'b1;
        end else begin
            stb_prev <= ctl.stb;
            if (mode != CELL_HOLD)
                q <= d;
        end
    end
endmodule

// File: rtl/utx_half.sv
`timescale 1ns/1ps
module utx_half
    import utx_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_drv,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_drv,
    input  ctl_t         ab_ctl,
    input  logic         ab_en,
    input  ctl_t         ba_ctl,
    input  logic         ba_en_n,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic         fight
);
    logic [W-1:0] a_eff, b_eff, ab_q, ba_q;
    logic         ba_en;

    assign ba_en = ~ba_en_n;

    utx_keeper #(.W(W)) u_keep_a (
        .clk(clk), .rst(rst), .pin_in(a_in), .pin_drv(a_drv), .eff(a_eff)
    );
    utx_keeper #(.W(W)) u_keep_b (
        .clk(clk), .rst(rst), .pin_in(b_in), .pin_drv(b_drv), .eff(b_eff)
    );

    utx_cell #(.W(W)) u_ab (
        .clk(clk), .rst(rst), .ctl(ab_ctl), .d(a_eff), .q_out(ab_q)
    );
    utx_cell #(.W(W)) u_ba (
        .clk(clk), .rst(rst), .ctl(ba_ctl), .d(b_eff), .q_out(ba_q)
    );

    assign b_oe  = {W{ab_en}};
    assign b_out = ab_en ? ab_q : '0;
    assign a_oe  = {W{ba_en}};
    assign a_out = ba_en ? ba_q : '0;
    assign fight = ab_en & ba_en;
endmodule

// File: rtl/utx_transceiver.sv
`timescale 1ns/1ps
module utx_transceiver
    import utx_pkg::*;
#(
    parameter int HALF_W = 18,
    parameter int HALVES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [HALF_W*HALVES-1:0] a_in,
    input  logic [HALF_W*HALVES-1:0] a_drv,
    input  logic [HALF_W*HALVES-1:0] b_in,
    input  logic [HALF_W*HALVES-1:0] b_drv,
    input  logic [HALVES-1:0]        ab_en,
    input  logic [HALVES-1:0]        ab_le,
    input  logic [HALVES-1:0]        ab_stb,
    input  logic [HALVES-1:0]        ba_en_n,
    input  logic [HALVES-1:0]        ba_le,
    input  logic [HALVES-1:0]        ba_stb,
    output logic [HALF_W*HALVES-1:0] b_out,
    output logic [HALF_W*HALVES-1:0] b_oe,
    output logic [HALF_W*HALVES-1:0] a_out,
    output logic [HALF_W*HALVES-1:0] a_oe,
    output logic [HALVES-1:0]        fight
);
    localparam int W = HALF_W * HALVES;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        ctl_t ab_ctl, ba_ctl;
        assign ab_ctl = '{le: ab_le[h], stb: ab_stb[h]};
        assign ba_ctl = '{le: ba_le[h], stb: ba_stb[h]};

        utx_half #(.W(HALF_W)) u_half (
            .clk     (clk),
            .rst     (rst),
            .a_in    (a_in [h*HALF_W +: HALF_W]),
            .a_drv   (a_drv[h*HALF_W +: HALF_W]),
            .b_in    (b_in [h*HALF_W +: HALF_W]),
            .b_drv   (b_drv[h*HALF_W +: HALF_W]),
            .ab_ctl  (ab_ctl),
            .ab_en   (ab_en[h]),
            .ba_ctl  (ba_ctl),
            .ba_en_n (ba_en_n[h]),
            .b_out   (b_out[h*HALF_W +: HALF_W]),
            .b_oe    (b_oe [h*HALF_W +: HALF_W]),
            .a_out   (a_out[h*HALF_W +: HALF_W]),
            .a_oe    (a_oe [h*HALF_W +: HALF_W]),
            .fight   (fight[h])
        );
    end

    if (W < 2) begin : g_width_guard
        initial $error("utx_transceiver: data width too small");
    end
endmodule

// File: rtl/utx_checker.sv
`timescale 1ns/1ps
module utx_checker #(
    parameter int HALF_W = 18,
    parameter int HALVES = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic [HALF_W*HALVES-1:0] a_in,
    input logic [HALF_W*HALVES-1:0] a_drv,
    input logic [HALVES-1:0]        ab_en,
    input logic [HALVES-1:0]        ab_le,
    input logic [HALVES-1:0]        ab_stb,
    input logic [HALVES-1:0]        ba_en_n,
    input logic [HALF_W*HALVES-1:0] b_out,
    input logic [HALF_W*HALVES-1:0] b_oe,
    input logic [HALF_W*HALVES-1:0] a_out,
    input logic [HALF_W*HALVES-1:0] a_oe,
    input logic [HALVES-1:0]        fight
);
    // cycles since the last reset edge, saturating, gates look-back depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_chk
        // R1: transparent path with fully driven source
        a_r1_follow: assert property (@(posedge clk) disable iff (rst)
            (ab_en[h] && ab_le[h] && (&a_drv[h*HALF_W +: HALF_W]))
            |-> b_out[h*HALF_W +: HALF_W] == a_in[h*HALF_W +: HALF_W]);

        // R2: no update window leaves the output unchanged
        a_r2_hold: assert property (@(posedge clk) disable iff (rst)
            (since_rst == 2'd3 && ab_en[h] && $past(ab_en[h]) && !ab_le[h]
             && !$past(ab_le[h]) && !($past(ab_stb[h]) && !$past(ab_stb[h], 2)))
            |-> $stable(b_out[h*HALF_W +: HALF_W]));

        // R3: rising strobe loads the prior-cycle source
        a_r3_capture: assert property (@(posedge clk) disable iff (rst)
            (since_rst == 2'd3 && ab_en[h] && !ab_le[h] && !$past(ab_le[h])
             && $past(ab_stb[h]) && !$past(ab_stb[h], 2)
             && $past(&a_drv[h*HALF_W +: HALF_W]))
            |-> b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W]));

        // R5: released B side reads zero
        a_r5_b_released: assert property (@(posedge clk) disable iff (rst)
            !ab_en[h] |-> (b_out[h*HALF_W +: HALF_W] == '0
                           && b_oe[h*HALF_W +: HALF_W] == '0));

        // R6: released A side reads zero
        a_r6_a_released: assert property (@(posedge clk) disable iff (rst)
            ba_en_n[h] |-> (a_out[h*HALF_W +: HALF_W] == '0
                            && a_oe[h*HALF_W +: HALF_W] == '0));

        // R9: a fight implies both sides are being driven
        a_r9_fight_both: assert property (@(posedge clk) disable iff (rst)
            fight[h] |-> ((&b_oe[h*HALF_W +: HALF_W]) && (&a_oe[h*HALF_W +: HALF_W])));
    end
endmodule

bind utx_transceiver utx_checker #(.HALF_W(HALF_W), .HALVES(HALVES)) u_chk (
    .clk(clk), .rst(rst), .a_in(a_in), .a_drv(a_drv),
    .ab_en(ab_en), .ab_le(ab_le), .ab_stb(ab_stb), .ba_en_n(ba_en_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe), .fight(fight)
);

// File: tb/utx_transceiver_test.sv
`timescale 1ns/1ps
module utx_transceiver_test;
    localparam int HW = 18;
    localparam int NH = 2;
    localparam int W  = HW * NH;

    localparam logic [W-1:0] ONES = '1;
    localparam logic [W-1:0] LO   = {{HW{1'b0}}, {HW{1'b1}}};
    localparam logic [W-1:0] HI   = {{HW{1'b1}}, {HW{1'b0}}};

    localparam logic [W-1:0] P1  = 36'h9_1234_5678;
    localparam logic [W-1:0] P2  = 36'h3_CAFE_0F0F;
    localparam logic [W-1:0] P3  = 36'h6_0055_AA11;
    localparam logic [W-1:0] P4  = 36'hA_BCDE_F012;
    localparam logic [W-1:0] P5  = 36'h5_5555_5555;
    localparam logic [W-1:0] P6  = 36'hF_0000_FFFF;
    localparam logic [W-1:0] P7  = 36'h1_8E3C_7A21;
    localparam logic [W-1:0] P8  = 36'h7_7777_0001;
    localparam logic [W-1:0] P9  = 36'hC_3C3C_3C3C;
    localparam logic [W-1:0] P10 = 36'h2_4680_ACE1;
    localparam logic [W-1:0] P11 = 36'hE_1357_9BDF;
    localparam logic [W-1:0] Q0  = 36'h4_2B2B_6D6D;
    localparam logic [W-1:0] Q1  = 36'hB_0101_0202;
    localparam logic [W-1:0] Q2  = 36'h8_F00D_BEEF;
    localparam logic [W-1:0] Q3  = 36'h0_DEAD_4321;
    localparam logic [W-1:0] Q4  = 36'hD_9999_6666;
    localparam logic [W-1:0] Q5  = 36'h2_0F0F_F0F0;
    localparam logic [W-1:0] Q6  = 36'h6_ABCD_1234;

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  a_in, a_drv, b_in, b_drv;
    logic [NH-1:0] ab_en, ab_le, ab_stb, ba_en_n, ba_le, ba_stb;
    logic [W-1:0]  b_out, b_oe, a_out, a_oe;
    logic [NH-1:0] fight;

    always #4 clk = ~clk;

    utx_transceiver #(.HALF_W(HW), .HALVES(NH)) uut (
        .clk(clk), .rst(rst), .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
        .ab_en(ab_en), .ab_le(ab_le), .ab_stb(ab_stb),
        .ba_en_n(ba_en_n), .ba_le(ba_le), .ba_stb(ba_stb),
        .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe), .fight(fight)
    );

    typedef enum int { K_BOUT, K_AOUT, K_BOE, K_AOE, K_FIGHT } kind_t;
    typedef struct {
        string        req;
        kind_t        kind;
        logic [W-1:0] exp;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    event  smp;

    task automatic chk(kind_t k, logic [W-1:0] e, string req);
        item_t it;
        it.req = req; it.kind = k; it.exp = e;
        exp_q.push_back(it);
    endtask

    task automatic fire();
        -> smp;
    endtask

    // monitor: pops expected items and compares with the live outputs
    initial begin
        forever begin
            @(smp);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [W-1:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_BOUT:  act = b_out;
                    K_AOUT:  act = a_out;
                    K_BOE:   act = b_oe;
                    K_AOE:   act = a_oe;
                    default: act = {{(W-NH){1'b0}}, fight};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        a_in = '0; a_drv = ONES; b_in = '0; b_drv = ONES;
        ab_en = 2'b11; ab_le = 2'b00; ab_stb = 2'b00;
        ba_en_n = 2'b11; ba_le = 2'b00; ba_stb = 2'b00;
        repeat (2) @(negedge clk);

        // step 0: reset released, storage cleared, A side released
        rst = 1'b0; a_in = P1; b_drv = '0; b_in = Q5;
        #2;
        chk(K_BOUT, '0, "R10 storage cleared");
        chk(K_AOE, '0, "R6 released A enable");
        chk(K_AOUT, '0, "R6 released A data");
        chk(K_BOE, ONES, "R5 enabled B drive");
        fire();

        // step 1: B keeper never driven since reset, BA transparent on half 0
        @(negedge clk);
        ba_en_n = 2'b10; ba_le = 2'b01;
        #2;
        chk(K_AOUT, '0, "R10 keeper cleared");
        chk(K_FIGHT, 36'd1, "R9 half0 fight");
        fire();

        // step 2: B driven, AB released while transparent
        @(negedge clk);
        b_drv = ONES; b_in = Q0; ab_en = 2'b00; ab_le = 2'b11; a_in = P2;
        #2;
        chk(K_AOUT, Q0 & LO, "R1 BA transparent half0, R7 half1 idle");
        chk(K_FIGHT, '0, "R9 no fight");
        chk(K_BOUT, '0, "R5 B data released");
        chk(K_BOE, '0, "R5 B enable released");
        fire();

        // step 3: AB transparent on both halves
        @(negedge clk);
        ab_en = 2'b11; a_in = P1; ba_en_n = 2'b11; ba_le = 2'b00;
        #2;
        chk(K_BOUT, P1, "R1 AB transparent");
        fire();

        // steps 4-5: latch enable low with strobe low
        @(negedge clk);
        ab_le = 2'b00; a_in = P2;
        #2;
        chk(K_BOUT, P1, "R2 hold after le falls");
        fire();
        @(negedge clk);
        a_in = P3;
        #2;
        chk(K_BOUT, P1, "R2 data change ignored");
        fire();

        // steps 6-7: rising strobe captures
        @(negedge clk);
        ab_stb = 2'b11; a_in = P4;
        #2;
        chk(K_BOUT, P1, "R3 not before edge");
        fire();
        @(negedge clk);
        a_in = P5;
        #2;
        chk(K_BOUT, P4, "R3 captured on rise");
        fire();

        // step 8: falling strobe ignored
        @(negedge clk);
        ab_stb = 2'b00; a_in = P6;
        #2;
        chk(K_BOUT, P4, "R2 falling strobe ignored");
        fire();

        // steps 9-10: strobe on half 1 only
        @(negedge clk);
        ab_stb = 2'b10; a_in = P7;
        #2;
        chk(K_BOUT, P4, "R7 before half1 edge");
        fire();
        @(negedge clk);
        a_in = P8;
        #2;
        chk(K_BOUT, (P7 & HI) | (P4 & LO), "R7 only half1 captured");
        fire();

        // steps 11-13: latch enable falls while strobe is high
        @(negedge clk);
        ab_stb = 2'b11; ab_le = 2'b11; a_in = P9;
        #2;
        chk(K_BOUT, P9, "R1 transparent with strobe high");
        fire();
        @(negedge clk);
        ab_le = 2'b00; a_in = P10;
        #2;
        chk(K_BOUT, P9, "R4 value before le fell");
        fire();
        @(negedge clk);
        a_in = P11;
        #2;
        chk(K_BOUT, P9, "R4 high strobe no capture");
        fire();

        // step 14: BA hold, stored Q0 on half0 only
        @(negedge clk);
        ab_en = 2'b00; ba_en_n = 2'b00; b_in = Q1;
        #2;
        chk(K_AOUT, Q0 & LO, "R2 BA hold");
        chk(K_AOE, ONES, "R6 A enable active low");
        fire();

        // steps 15-16: BA capture
        @(negedge clk);
        ba_stb = 2'b11; b_in = Q2;
        #2;
        chk(K_AOUT, Q0 & LO, "R3 BA not before edge");
        fire();
        @(negedge clk);
        b_in = Q3;
        #2;
        chk(K_AOUT, Q2, "R3 BA captured on rise");
        fire();

        // steps 17-19: B keeper
        @(negedge clk);
        b_drv = '0; b_in = Q4; ba_le = 2'b11;
        #2;
        chk(K_AOUT, Q3, "R8 keeper last driven");
        fire();
        @(negedge clk);
        b_in = Q5;
        #2;
        chk(K_AOUT, Q3, "R8 keeper ignores floating input");
        fire();
        @(negedge clk);
        b_drv = LO; b_in = Q6;
        #2;
        chk(K_AOUT, (Q3 & HI) | (Q6 & LO), "R8 per-bit keeper");
        fire();

        // step 20: mixed enables across halves
        @(negedge clk);
        b_drv = ONES; ab_en = 2'b10; ba_en_n = 2'b01;
        #2;
        chk(K_FIGHT, 36'd2, "R9 half1 fight");
        chk(K_BOE, HI, "R7 B enable per half");
        chk(K_AOE, HI, "R7 A enable per half");
        fire();

        // steps 21-22: reset with strobe held high
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; ab_en = 2'b11; ba_en_n = 2'b11; ab_le = 2'b00; ab_stb = 2'b11;
        a_in = P5;
        #2;
        chk(K_BOUT, '0, "R10 storage cleared mid-run");
        fire();
        @(negedge clk);
        a_in = P6;
        #2;
        chk(K_BOUT, '0, "R10 held strobe no capture");
        fire();

        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule